// File: doc/BRIEF.md
# Chip-Select-Framed Serial Target with Leftover-Bit Reporting

This block is the target (slave) end of a four-wire serial peripheral link. It runs entirely on the local system clock. The link inputs (serial clock, select and inbound data) are first passed through two-flop synchronisers. Serial-clock edges are then detected in the system domain. Each edge is classed as a sample edge or a shift edge, according to the selected clock polarity and clock phase.

Inbound bits are gathered MSB first into bytes and handed to a local sink. Outbound bytes are pulled from a local valid/ready source and driven MSB first. When the source has nothing to offer, all-ones bytes are sent instead.

A pulse marks the start of each transaction, and a second pulse marks its end. The end pulse carries three counts: whole bytes received, leftover bits received after the last whole byte, and source bytes that the master actually sampled. Leftover bits are passed on as one extra byte, flagged as partial. They are packed toward the MSB, with zeros below. The system clock must run at least four times faster than the serial clock, and the mode inputs must be held steady while the target is selected.

Top module: `spi_target`

## Requirements
- R1: Each high-to-low transition of `cs_n` produces exactly one single-cycle `txn_start` pulse, and never in the same cycle as `txn_end`.
- R2: Each low-to-high transition of `cs_n` produces exactly one single-cycle `txn_end` pulse. The `end_*` count outputs are updated in that cycle and hold their value until the next end pulse.
- R3: `end_rx_bytes` equals the number of whole 8-bit groups sampled from `mosi`, and `end_rx_bits` equals the number of sampled bits beyond them (0 to 7).
- R4: Each whole received byte appears once on `rx_data` with `rx_valid`=1 and `rx_partial`=0. The first bit sampled sits in bit 7.
- R5: If `end_rx_bits` is nonzero, one extra byte appears in the `txn_end` cycle with `rx_valid`=1 and `rx_partial`=1. Its leftover bits fill it from bit 7 downward in sampling order, and every lower bit is 0.
- R6: Outbound bytes come from the source in order. A byte is taken when `tx_valid` is high during a single-cycle `tx_ready` strobe, and it is driven on `miso` MSB first.
- R7: If `tx_valid` is low at a fetch strobe, that byte slot is sent as 0xFF.
- R8: `end_tx_bytes` counts source bytes of which the master sampled at least one bit.
- R9: All four (cpol, cpha) modes work. The sample edge is the rising edge when cpol equals cpha, and the falling edge otherwise. With cpha=0 the first bit is driven soon after select assertion. With cpha=1 each bit is driven on the leading edge.
- R10: All bit and byte counters clear at each select assertion, so every transaction reports only its own traffic.
- R11: `miso_oe` is 1 while the target is selected and 0 while it is deselected, including the cycle after `txn_end`.
- R12: After reset, `miso_oe`, `txn_start`, `txn_end`, `rx_valid` and every `end_*` output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Clock phase: 0 samples on the leading edge, 1 on the trailing edge |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low select from the master |
| mosi | input | 1 | Inbound serial data |
| miso | output | 1 | Outbound serial data |
| miso_oe | output | 1 | Output enable for the `miso` pad |
| tx_data | input | DATA_W | Outbound byte offered by the source |
| tx_valid | input | 1 | Source has a byte |
| tx_ready | output | 1 | Fetch strobe; byte taken if `tx_valid` |
| rx_data | output | DATA_W | Received byte |
| rx_valid | output | 1 | `rx_data` valid this cycle |
| rx_partial | output | 1 | `rx_data` is a leftover partial byte |
| txn_start | output | 1 | Transaction start pulse |
| txn_end | output | 1 | Transaction end pulse |
| end_rx_bytes | output | CNT_W | Whole bytes received |
| end_rx_bits | output | BIT_W | Leftover bits received |
| end_tx_bytes | output | CNT_W | Source bytes sampled by the master |

## Verification
Several properties are checked on every cycle: start and end pulses never coincide, a partial byte only appears with the end pulse and has zero low bits, the output enable is raised with the start pulse and dropped after the end pulse, and the counters read zero just after a select assertion. Other behaviour can only be shown by the bench scenarios. These scenarios cover the bit order on both data lines in each mode, the 0xFF fill when the source runs dry, the transmit count when a byte is fetched but never sampled, and the exact byte and leftover counts for lengths from zero upward.

// File: rtl/spit_pkg.sv
package spit_pkg;

  // Per-cycle link events derived from synchronised inputs
  typedef struct packed {
    logic sel_on;   // select just asserted
    logic sel_off;  // select just released
    logic smp;      // sample edge while selected
    logic shf;      // shift edge while selected
  } spit_ev_t;

  // Sampling happens on the rising edge when polarity equals phase
  function automatic logic smp_on_rise(input logic pol, input logic pha);
    return pol == pha;
  endfunction

endpackage

// File: rtl/spit_sync.sv
module spit_sync #(
  parameter int              W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[i];
        stab_q <= RST_VAL[i];
      end else begin
        meta_q <= d[i];
        stab_q <= meta_q;
      end
    end
    assign q[i] = stab_q;
  end

endmodule

// File: rtl/spit_edge.sv
module spit_edge
  import spit_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sclk_s,
  input  logic     csn_s,
  input  logic     cpol,
  input  logic     cpha,
  output spit_ev_t ev
);

  logic sclk_q, csn_q;
  logic sclk_d, csn_d;
  logic rise, fall, sel_steady, rise_is_smp;

  always_comb begin
    sclk_d = sclk_s;
    csn_d  = csn_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
    end else begin
      sclk_q <= sclk_d;
      csn_q  <= csn_d;
    end
  end

  always_comb begin
    rise        = sclk_s & ~sclk_q;
    fall        = ~sclk_s & sclk_q;
    sel_steady  = ~csn_s & ~csn_q;
    rise_is_smp = smp_on_rise(cpol, cpha);
    ev.sel_on   = ~csn_s & csn_q;
    ev.sel_off  = csn_s & ~csn_q;
    ev.smp      = sel_steady & (rise_is_smp ? rise : fall);
    ev.shf      = sel_steady & (rise_is_smp ? fall : rise);
  end

endmodule

// File: rtl/spit_shift.sv
module spit_shift
  import spit_pkg::*;
#(
  parameter  int DATA_W = 8,
  parameter  int CNT_W  = 16,
  localparam int BIT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpha,
  input  logic              mosi_s,
  input  spit_ev_t          ev,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              miso,
  output logic              miso_oe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_partial,
  output logic              txn_start,
  output logic              txn_end,
  output logic [CNT_W-1:0]  end_rx_bytes,
  output logic [BIT_W-1:0]  end_rx_bits,
  output logic [CNT_W-1:0]  end_tx_bytes
);

  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);
  localparam logic [BIT_W:0]   DW_V     = (BIT_W+1)'(DATA_W);

  logic [DATA_W-1:0] tx_sh_q, tx_sh_d, rx_sh_q, rx_sh_d, rxd_q, rxd_d;
  logic              tx_src_q, tx_src_d, oe_q, oe_d;
  logic              rxv_q, rxv_d, rxp_q, rxp_d, st_q, st_d, en_q, en_d;
  logic [BIT_W-1:0]  bit_q, bit_d, ebits_q, ebits_d;
  logic [CNT_W-1:0]  rxb_q, rxb_d, txb_q, txb_d, erxb_q, erxb_d, etxb_q, etxb_d;
  logic              first_bit, last_bit, load;
  logic [BIT_W:0]    sh_amt;

  always_comb begin
    first_bit = (bit_q == '0);
    last_bit  = (bit_q == LAST_BIT);
    load      = (ev.sel_on & ~cpha) | (ev.shf & first_bit);
    sh_amt    = DW_V - {1'b0, bit_q};

    tx_sh_d  = tx_sh_q;
    tx_src_d = tx_src_q;
    rx_sh_d  = rx_sh_q;
    bit_d    = bit_q;
    rxb_d    = rxb_q;
    txb_d    = txb_q;
    oe_d     = oe_q;
    rxd_d    = rxd_q;
    rxv_d    = 1'b0;
    rxp_d    = 1'b0;
    st_d     = 1'b0;
    en_d     = 1'b0;
    erxb_d   = erxb_q;
    ebits_d  = ebits_q;
    etxb_d   = etxb_q;

    if (ev.sel_on) begin
      bit_d    = '0;
      rxb_d    = '0;
      txb_d    = '0;
      st_d     = 1'b1;
      oe_d     = 1'b1;
      tx_src_d = 1'b0;
      tx_sh_d  = '1;
    end

    if (load) begin
      tx_sh_d  = tx_valid ? tx_data : '1;
      tx_src_d = tx_valid;
    end else if (ev.shf) begin
      tx_sh_d = {tx_sh_q[DATA_W-2:0], 1'b1};
    end

    if (ev.smp) begin
      rx_sh_d = {rx_sh_q[DATA_W-2:0], mosi_s};
      bit_d   = last_bit ? '0 : bit_q + BIT_W'(1);
      if (first_bit && tx_src_q) txb_d = txb_q + CNT_W'(1);
      if (last_bit) begin
        rxb_d = rxb_q + CNT_W'(1);
        rxv_d = 1'b1;
        rxd_d = {rx_sh_q[DATA_W-2:0], mosi_s};
      end
    end

    if (ev.sel_off) begin
      en_d    = 1'b1;
      oe_d    = 1'b0;
      erxb_d  = rxb_q;
      ebits_d = bit_q;
      etxb_d  = txb_q;
      if (!first_bit) begin
        rxv_d = 1'b1;
        rxp_d = 1'b1;
        rxd_d = rx_sh_q << sh_amt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh_q  <= '1;
      tx_src_q <= 1'b0;
      rx_sh_q  <= '0;
      bit_q    <= '0;
      rxb_q    <= '0;
      txb_q    <= '0;
      oe_q     <= 1'b0;
      rxd_q    <= '0;
      rxv_q    <= 1'b0;
      rxp_q    <= 1'b0;
      st_q     <= 1'b0;
      en_q     <= 1'b0;
      erxb_q   <= '0;
      ebits_q  <= '0;
      etxb_q   <= '0;
    end else begin
      tx_sh_q  <= tx_sh_d;
      tx_src_q <= tx_src_d;
      rx_sh_q  <= rx_sh_d;
      bit_q    <= bit_d;
      rxb_q    <= rxb_d;
      txb_q    <= txb_d;
      oe_q     <= oe_d;
      rxd_q    <= rxd_d;
      rxv_q    <= rxv_d;
      rxp_q    <= rxp_d;
      st_q     <= st_d;
      en_q     <= en_d;
      erxb_q   <= erxb_d;
      ebits_q  <= ebits_d;
      etxb_q   <= etxb_d;
    end
  end

  assign tx_ready     = load;
  assign miso         = tx_sh_q[DATA_W-1];
  assign miso_oe      = oe_q;
  assign rx_data      = rxd_q;
  assign rx_valid     = rxv_q;
  assign rx_partial   = rxp_q;
  assign txn_start    = st_q;
  assign txn_end      = en_q;
  assign end_rx_bytes = erxb_q;
  assign end_rx_bits  = ebits_q;
  assign end_tx_bytes = etxb_q;

  // R5
  partial_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxv_q && rxp_q) |-> ((DATA_W'(rxd_q << ebits_q) == '0) && (ebits_q != '0)));

  // R5
  partial_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxv_q && rxp_q) |-> en_q);

  // R10
  count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev.sel_on |=> (bit_q == '0 && rxb_q == '0 && txb_q == '0));

  // R11
  oe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> !oe_q);

endmodule

// File: rtl/spi_target.sv
module spi_target
  import spit_pkg::*;
#(
  parameter  int DATA_W = 8,
  parameter  int CNT_W  = 16,
  localparam int BIT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_partial,
  output logic              txn_start,
  output logic              txn_end,
  output logic [CNT_W-1:0]  end_rx_bytes,
  output logic [BIT_W-1:0]  end_rx_bits,
  output logic [CNT_W-1:0]  end_tx_bytes
);

  logic [1:0] rst_q;
  logic       rst_sn;
  logic [2:0] link_s;
  spit_ev_t   ev;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sn = rst_q[1];

  // bit 2: select (idles high), bit 1: serial clock, bit 0: inbound data
  spit_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_sn),
    .d     ({cs_n, sclk, mosi}),
    .q     (link_s)
  );

  spit_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_sn),
    .sclk_s (link_s[1]),
    .csn_s  (link_s[2]),
    .cpol   (cpol),
    .cpha   (cpha),
    .ev     (ev)
  );

  spit_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk          (clk),
    .rst_n        (rst_sn),
    .cpha         (cpha),
    .mosi_s       (link_s[0]),
    .ev           (ev),
    .tx_data      (tx_data),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .miso         (miso),
    .miso_oe      (miso_oe),
    .rx_data      (rx_data),
    .rx_valid     (rx_valid),
    .rx_partial   (rx_partial),
    .txn_start    (txn_start),
    .txn_end      (txn_end),
    .end_rx_bytes (end_rx_bytes),
    .end_rx_bits  (end_rx_bits),
    .end_tx_bytes (end_tx_bytes)
  );

  // R1
  start_end_apart_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !(txn_start && txn_end));

  // R11
  oe_with_start_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    txn_start |-> miso_oe);

endmodule

// File: tb/sim_spi_target.sv
module sim_spi_target;

  localparam int H = 8;  // serial half period in system clocks

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpol, cpha, sclk, cs_n, mosi;
  logic        miso, miso_oe;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_ready;
  logic [7:0]  rx_data;
  logic        rx_valid, rx_partial, txn_start, txn_end;
  logic [15:0] end_rx_bytes, end_tx_bytes;
  logic [2:0]  end_rx_bits;

  always #2 clk = ~clk;

  spi_target u0 (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .sclk(sclk),
    .cs_n(cs_n), .mosi(mosi), .miso(miso), .miso_oe(miso_oe),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_partial(rx_partial),
    .txn_start(txn_start), .txn_end(txn_end), .end_rx_bytes(end_rx_bytes),
    .end_rx_bits(end_rx_bits), .end_tx_bytes(end_tx_bytes)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // transmit source
  logic [7:0] pool [0:7];
  logic [3:0] pidx;
  int         pk;
  logic       pclr;
  assign tx_valid = (int'(pidx) < pk);
  assign tx_data  = pool[pidx[2:0]];
  always @(posedge clk) begin
    if (pclr) pidx <= '0;
    else if (tx_valid && tx_ready) pidx <= pidx + 4'd1;
  end

  // output monitor
  logic [7:0] got_b [0:15];
  logic       got_p [0:15];
  int         got_n, starts, ends;
  initial begin got_n = 0; starts = 0; ends = 0; end
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid && got_n < 16) begin
        got_b[got_n] = rx_data;
        got_p[got_n] = rx_partial;
        got_n++;
      end
      if (txn_start) starts++;
      if (txn_end) ends++;
    end
  end

  logic mb [0:63];
  logic mo [0:63];

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_miso(input int i, input int k);
    logic [7:0] v;
    v = ((i / 8) < k) ? pool[i / 8] : 8'hFF;
    return v[7 - (i % 8)];
  endfunction

  function automatic logic [7:0] exp_byte(input int j, input int nbits);
    logic [7:0] v;
    v = '0;
    for (int b = 0; b < 8; b++)
      if (8 * j + b < nbits) v[7 - b] = mb[8 * j + b];
    return v;
  endfunction

  task automatic txn(input logic pl, input logic ph, input int n, input int k);
    int s0, e0, nfull, nrem, nexp, miso_bad, tx_exp;
    cpol = pl; cpha = ph; sclk = pl; mosi = 1'b0; pk = k;
    for (int i = 0; i < 8; i++) pool[i] = 8'($urandom);
    for (int i = 0; i < 64; i++) mb[i] = 1'($urandom);
    pclr = 1'b1; tick(1); pclr = 1'b0;
    tick(6);
    got_n = 0; s0 = starts; e0 = ends;
    cs_n = 1'b0; tick(H);
    chk(miso_oe == 1'b1, "R11 oe while selected", miso_oe, 1);
    for (int i = 0; i < n; i++) begin
      if (!ph) begin
        mosi = mb[i]; tick(H); sclk = ~pl; mo[i] = miso; tick(H); sclk = pl;
      end else begin
        sclk = ~pl; mosi = mb[i]; tick(H); sclk = pl; mo[i] = miso; tick(H);
      end
    end
    tick(H);
    cs_n = 1'b1; tick(10);
    nfull = n / 8; nrem = n % 8; nexp = nfull + (nrem != 0 ? 1 : 0);
    tx_exp = (k < (n + 7) / 8) ? k : (n + 7) / 8;
    chk(starts - s0 == 1, "R1 start count", starts - s0, 1);
    chk(ends - e0 == 1, "R2 end count", ends - e0, 1);
    chk(int'(end_rx_bytes) == nfull, "R3 whole bytes", end_rx_bytes, nfull);
    chk(int'(end_rx_bits) == nrem, "R3 leftover bits", end_rx_bits, nrem);
    chk(int'(end_tx_bytes) == tx_exp, "R8 tx bytes", end_tx_bytes, tx_exp);
    chk(miso_oe == 1'b0, "R11 oe after deselect", miso_oe, 0);
    chk(got_n == nexp, "R4 rx byte count", got_n, nexp);
    for (int j = 0; j < nexp && j < got_n; j++) begin
      if (j < nfull)
        chk(got_b[j] == exp_byte(j, n) && !got_p[j], "R4 full byte", got_b[j], exp_byte(j, n));
      else
        chk(got_b[j] == exp_byte(j, n) && got_p[j], "R5 partial byte", got_b[j], exp_byte(j, n));
    end
    miso_bad = 0;
    for (int i = 0; i < n; i++) if (mo[i] !== exp_miso(i, k)) miso_bad++;
    chk(miso_bad == 0, (k == 0) ? "R7 fill bits" : "R6 R9 miso bits", miso_bad, 0);
  endtask

  initial begin
    void'($urandom(32'd7031));
    rst_n = 1'b0; cpol = 1'b0; cpha = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0;
    pclr = 1'b1; pk = 0;
    tick(5);
    rst_n = 1'b1;
    tick(6);
    pclr = 1'b0;
    // R12 reset state
    chk(miso_oe == 1'b0, "R12 oe", miso_oe, 0);
    chk(!txn_start && !txn_end && !rx_valid, "R12 pulses", {txn_start, txn_end, rx_valid}, 0);
    chk(end_rx_bytes == 0 && end_rx_bits == 0 && end_tx_bytes == 0, "R12 counts",
        end_rx_bytes + end_tx_bytes + end_rx_bits, 0);
    // directed corners
    txn(1'b0, 1'b0, 0, 3);   // R10 no clocks: fetched byte not counted
    txn(1'b0, 1'b0, 8, 1);   // exact byte, mode 0
    txn(1'b0, 1'b1, 3, 2);   // R5 short partial, mode 1
    txn(1'b1, 1'b0, 17, 0);  // R7 all fill, mode 2
    txn(1'b1, 1'b1, 23, 7);  // mode 3, long partial
    txn(1'b0, 1'b0, 16, 1);  // R7 fill after source runs dry
    txn(1'b1, 1'b1, 1, 4);   // single bit
    for (int t = 0; t < 30; t++)
      txn(1'($urandom), 1'($urandom), $urandom_range(0, 44), $urandom_range(0, 7));
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule